// File: doc/BRIEF.md
# Triple-Redundant Handshake Sequencer

This block is a four-state control sequencer that runs one request and one acknowledgement per job. It keeps three copies of its 2-bit state register. A run starts from idle when `start` is seen. The sequencer spends one cycle issuing a request. It then waits for `ready`, reports completion for one cycle and returns to idle. `abort` sends an active job straight back to idle.

The state logic is triplicated, and so is the voting. Each copy has its own bitwise two-of-three voter over all three registers. The next state of each copy is computed from that copy's voted value, never from its own raw register. A copy that has been upset is therefore overwritten with the agreed state at the next clock edge. The three control outputs are decoded once per copy and voted again, so no single voter or decoder drives a pin alone.

Each copy has an upset input. It flips chosen state bits of that copy at a clock edge, which allows recovery to be exercised. A `mismatch` output shows whenever some copy disagrees with its vote.

Top module: `tmr_fsm`

## Requirements
- R1: `rst` is synchronous and active high. At an edge where it is sampled high, all three copies are cleared to idle and the upset masks are ignored. While in reset and right after it, `req`, `busy`, `done` and `mismatch` are low.
- R2: In idle, a high `start` with `abort` low moves the sequencer to the request state at the next edge. Without `start` it stays idle.
- R3: The request state lasts exactly one cycle and is followed by the waiting state. `req` is high only in the request state. `busy` is high in the request and waiting states.
- R4: In the waiting state the sequencer stays put while `ready` is low. When `ready` is high and `abort` is low, it moves to the done state.
- R5: The done state lasts one cycle and is followed by idle. `done` is high only in the done state.
- R6: `abort` high in the request or waiting state returns the sequencer to idle at the next edge, and it overrides `ready`. In idle, `abort` high blocks `start`.
- R7: The state code is idle=00, request=01, waiting=10, done=11. The 2-bit mask on `upsetN` is XORed into copy N's register at the clock edge, with mask bit 0 acting on state bit 0.
- R8: An upset in one copy alone changes none of `req`, `busy`, `done` or the following state sequence. That copy holds the agreed state again after the next edge.
- R9: `mismatch` is high exactly while at least one copy differs from the bitwise majority of the three. After a single-copy upset it stays high for one cycle.
- R10: When two or more copies are upset, the bitwise majority of the corrupted registers becomes the state. All copies follow it from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job from idle |
| abort | input | 1 | Cancel the active job |
| ready | input | 1 | Acknowledgement that ends waiting |
| upset0 | input | 2 | Bit-flip mask for copy 0 |
| upset1 | input | 2 | Bit-flip mask for copy 1 |
| upset2 | input | 2 | Bit-flip mask for copy 2 |
| req | output | 1 | Voted request strobe |
| busy | output | 1 | Voted job-active flag |
| done | output | 1 | Voted completion strobe |
| mismatch | output | 1 | Some copy disagrees with its vote |

## Verification
The coincidence that matters is an upset landing in the same edge as a functional transition. Examples are a flipped copy while `start` is taken, while `abort` cancels a job, or while `ready` ends waiting. In that case the corrected copy must realign to the new state and not to the old one. The bench drives these pairs in one cycle and also stacks upsets on two or three copies. Each cycle it compares every output against a behavioural model that keeps three state variables and votes them bit by bit.

// File: rtl/tmr_fsm.sv
module tmr_fsm #(
  parameter int COPIES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       abort,
  input  logic       ready,
  input  logic [1:0] upset0,
  input  logic [1:0] upset1,
  input  logic [1:0] upset2,
  output logic       req,
  output logic       busy,
  output logic       done,
  output logic       mismatch
);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_RUN  = 2'd1;
  localparam logic [1:0] S_WAIT = 2'd2;
  localparam logic [1:0] S_DONE = 2'd3;

  logic [1:0] cp  [COPIES];
  logic [1:0] vt  [COPIES];
  logic [1:0] nx  [COPIES];
  logic [1:0] inj [COPIES];
  logic [2:0] dec [COPIES];
  logic [COPIES-1:0] diff;

  function automatic logic [1:0] maj2(input logic [1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [2:0] maj3(input logic [2:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [1:0] step(input logic [1:0] s, input logic st, ab, rd);
    case (s)
      S_IDLE:  return (st && !ab) ? S_RUN : S_IDLE;
      S_RUN:   return ab ? S_IDLE : S_WAIT;
      S_WAIT:  return ab ? S_IDLE : (rd ? S_DONE : S_WAIT);
      default: return S_IDLE;
    endcase
  endfunction

  assign inj[0] = upset0;
  assign inj[1] = upset1;
  assign inj[2] = upset2;

  always_comb begin
    for (int i = 0; i < COPIES; i++) begin
      vt[i]   = maj2(cp[0], cp[1], cp[2]);
      nx[i]   = step(vt[i], start, abort, ready);
      dec[i]  = {vt[i] == S_DONE, (vt[i] == S_RUN) || (vt[i] == S_WAIT), vt[i] == S_RUN};
      diff[i] = cp[i] != vt[i];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < COPIES; i++) begin
      if (rst) cp[i] <= S_IDLE;
      else     cp[i] <= nx[i] ^ inj[i];
    end
  end

  logic [2:0] outv;
  assign outv     = maj3(dec[0], dec[1], dec[2]);
  assign req      = outv[0];
  assign busy     = outv[1];
  assign done     = outv[2];
  assign mismatch = |diff;

  logic [2:0] hit;
  assign hit = {|upset2, |upset1, |upset0};

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (cp[0] == S_IDLE && cp[1] == S_IDLE && cp[2] == S_IDLE));

  assert_realign_R8: assert property (@(posedge clk) disable iff (rst)
    (hit == 3'b000) |=> (cp[0] == cp[1] && cp[1] == cp[2]));

  assert_single_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(hit) && mismatch && hit == 3'b000) |=> !mismatch);

  assert_single_upset_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ($countones(hit) == 1) |=> mismatch);

  assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (abort && $onehot0(hit)) |=> (!req && !busy && !done));

  assert_req_once_R3: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(hit) && req && !abort) |=> (busy && !req));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

endmodule

// File: tb/sim_tmr_fsm.sv
module sim_tmr_fsm;
  logic clk = 1'b0;
  logic rst, start, abort, ready;
  logic [1:0] upset0, upset1, upset2;
  logic req, busy, done, mismatch;
  int checks = 0;
  int errors = 0;
  logic [1:0] ms [3];

  always #2.5 clk = ~clk;

  tmr_fsm u0 (.clk(clk), .rst(rst), .start(start), .abort(abort), .ready(ready),
              .upset0(upset0), .upset1(upset1), .upset2(upset2),
              .req(req), .busy(busy), .done(done), .mismatch(mismatch));

  function automatic logic [1:0] vote(input logic [1:0] a, b, c);
    logic [1:0] r;
    for (int k = 0; k < 2; k++) r[k] = (int'(a[k]) + int'(b[k]) + int'(c[k])) >= 2;
    return r;
  endfunction

  function automatic logic [1:0] nextst(input logic [1:0] s, input logic st, ab, rd);
    logic [1:0] r;
    r = s;
    if (s == 2'd0 && st && !ab) r = 2'd1;
    else if (s == 2'd1) r = ab ? 2'd0 : 2'd2;
    else if (s == 2'd2) r = ab ? 2'd0 : (rd ? 2'd3 : 2'd2);
    else if (s == 2'd3) r = 2'd0;
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic [1:0] v;
    v = vote(ms[0], ms[1], ms[2]);
    chk(tag, "req", req, v == 2'd1);
    chk(tag, "busy", busy, v == 2'd1 || v == 2'd2);
    chk(tag, "done", done, v == 2'd3);
    chk(tag, "mismatch", mismatch, (ms[0] != v) || (ms[1] != v) || (ms[2] != v));
  endtask

  task automatic cyc(input logic r, s, a, rd, input logic [1:0] m0, m1, m2, input string tag);
    logic [1:0] v;
    rst = r; start = s; abort = a; ready = rd;
    upset0 = m0; upset1 = m1; upset2 = m2;
    @(posedge clk);
    v = vote(ms[0], ms[1], ms[2]);
    if (r) begin
      ms[0] = 2'd0; ms[1] = 2'd0; ms[2] = 2'd0;
    end else begin
      ms[0] = nextst(v, s, a, rd) ^ m0;
      ms[1] = nextst(v, s, a, rd) ^ m1;
      ms[2] = nextst(v, s, a, rd) ^ m2;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ms[0] = 2'd0; ms[1] = 2'd0; ms[2] = 2'd0;
    rst = 1'b1; start = 0; abort = 0; ready = 0;
    upset0 = 0; upset1 = 0; upset2 = 0;
    @(negedge clk);
    // R1: reset with upsets and start present
    cyc(1, 1, 0, 0, 2'b11, 2'b01, 2'b10, "R1");
    cyc(1, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 0, "R2");
    // R2..R5: full handshake
    cyc(0, 1, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 0, 0, 0, "R4");
    cyc(0, 0, 0, 0, 0, 0, 0, "R5");
    // R6: abort blocks start in idle, cancels in request and waiting
    cyc(0, 1, 1, 0, 0, 0, 0, "R6");
    cyc(0, 1, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, 0, 0, "R6");
    cyc(0, 1, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 1, 0, 0, 0, "R6");
    // R8 R9: single upsets, including coinciding with transitions
    cyc(0, 0, 0, 0, 2'b01, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, 2'b11, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 2'b10, "R8");
    cyc(0, 0, 0, 1, 2'b11, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, 2'b01, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, 0, "R9");
    // R7 R10: two copies flipped, idle 00 ^ 01 -> request 01
    cyc(0, 0, 0, 0, 2'b01, 2'b01, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, 0, 0, 0, 0, "R6");
    // R7 R10: three different masks from idle vote to done 11
    cyc(0, 0, 0, 0, 2'b01, 2'b10, 2'b11, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, "R10");
    // R1: reset mid-job
    cyc(0, 1, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 0, 0, 0, 2'b10, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 0, "R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule